// File: doc/BRIEF.md
# Brown-out Reset Release Sequencer

The block decides when the core may leave reset after a power-on event or a supply dip. A brown-out comparator output arrives asynchronously, is brought into the reference clock domain and filtered. Any active trigger, whether power-on or a filtered brown-out, holds the core in reset, gates the system clock and blocks code execution. Once the trigger clears, several qualification delays run side by side, each a cycle counter on the free-running reference clock: oscillator start-up, the power-up delay (or a fail-safe delay in its place), the regulator settle interval, and a wait for PLL lock when a PLL clock is chosen.

The clock enable rises once the selected clock is qualified. Reset is released when the clock is qualified and the power-up delay has expired. Execution is enabled once, in addition, the regulator interval is over. A new trigger at any point restarts every counter. Two sticky status flags record a brown-out and a power-on event separately and are cleared only by explicit clear strobes. Low-power indications mask the clock and execution enables, but never the brown-out monitoring.

Top module: `bor_rst_seq`

## Requirements
- R1: While rst_ni is low and on the first cycle after it rises, core_rst_o=1, clk_en_o=0, exec_en_o=0, bor_flag_o=0 and por_flag_o=0.
- R2: After por_i falls, with no OST, no PLL and pwrt_cyc_i=N>0, the clock enable is high from the first rising edge after por_i is first sampled low. core_rst_o is still 1 after N of those edges and is 0 after N+1 edges. por_flag_o is 1.
- R3: With a crystal clock, the oscillator start-up count of OST_CYC cycles gates both clk_en_o and the release. Crystal clocks are osc_sel_i=3'b010 or 3'b011 with posc_mode_i=2'b01 (XT) or 2'b10 (HS), and osc_sel_i=3'b100 (secondary). Release and clock enable then come after max(OST_CYC, power-up delay)+1 edges.
- R4: With a PLL clock, selected by osc_sel_i=3'b001 or 3'b011, clk_en_o and release wait for pll_lock_i=1. Both follow one edge after lock is sampled high, once the other delays are over.
- R5: When pwrt_cyc_i=0 and a crystal clock is chosen, a delay of FSCM_CYC cycles replaces the power-up delay. With pwrt_cyc_i=0 and external clock mode (osc_sel_i=3'b010, posc_mode_i=2'b00), no delay applies and release comes one edge after por_i falls.
- R6: bor_trip_i (1 = supply below threshold) passes a two-flop synchronizer and a filter that needs FILT_LEN consecutive equal samples. A pulse of FILT_LEN-1 cycles has no effect. A held trip raises core_rst_o FILT_LEN+3 edges after it rises. After the trip falls, release comes FILT_LEN+3+N edges later.
- R7: A trigger during a release sequence restarts all counters. Release timing is then measured from the end of the new trigger.
- R8: bor_flag_o is set by a filtered brown-out, and por_flag_o is set by por_i. Each flag is cleared only by its own clear strobe, and a clear does not touch the other flag. A set in the same cycle as a clear wins.
- R9: exec_en_o rises only after reset is released and REG_CYC cycles have passed since the trigger ended. It is high after REG_CYC+1 edges and low after REG_CYC edges.
- R10: sleep_i=1 forces clk_en_o and exec_en_o low, and idle_i=1 forces exec_en_o low only. A brown-out trip during sleep still raises core_rst_o and sets bor_flag_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the sequencer |
| bor_trip_i | input | 1 | Asynchronous brown-out comparator output, 1 = supply low |
| por_i | input | 1 | Power-on event indication, 1 = active |
| osc_sel_i | input | 3 | Clock source select |
| posc_mode_i | input | 2 | Primary oscillator mode: 00 external, 01 XT, 10 HS, 11 off |
| pwrt_cyc_i | input | PWRT_W | Power-up delay in cycles, 0 = none |
| pll_lock_i | input | 1 | PLL lock indication |
| sleep_i | input | 1 | Sleep mode indication |
| idle_i | input | 1 | Idle mode indication |
| clr_bor_flag_i | input | 1 | Clear strobe for the brown-out flag |
| clr_por_flag_i | input | 1 | Clear strobe for the power-on flag |
| core_rst_o | output | 1 | Core reset, 1 = held in reset |
| clk_en_o | output | 1 | System clock enable |
| exec_en_o | output | 1 | Code execution enable |
| bor_flag_o | output | 1 | Sticky brown-out status |
| por_flag_o | output | 1 | Sticky power-on status |

## Verification
A counter that restarts or saturates wrongly moves the release edge of core_rst_o or exec_en_o by one or more cycles. Each release is therefore checked on the exact edge on both sides. A wrong clock decode shows up as release at the bare power-up delay instead of the start-up or fail-safe count, or as release without PLL lock. A faulty filter either lets a short comparator pulse reach core_rst_o and bor_flag_o, or shifts the trip edge, and both are caught within a few cycles of the pulse.

// File: rtl/bor_seq_pkg.sv
package bor_seq_pkg;

  typedef struct packed {
    logic ost_req;
    logic pll_req;
    logic xtal;
  } clk_cfg_t;

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // source encodings: 000 frc, 001 frc+pll, 010 primary, 011 primary+pll,
  // 100 secondary xtal, 101 lprc, 110/111 frc divided
  function automatic clk_cfg_t decode_clk(logic [2:0] sel, logic [1:0] pmode);
    clk_cfg_t c;
    logic     pxtal;
    pxtal = (pmode == 2'b01) || (pmode == 2'b10);
    c     = '0;
    case (sel)
      3'b001: c.pll_req = 1'b1;
      3'b010: c.xtal = pxtal;
      3'b011: begin c.xtal = pxtal; c.pll_req = 1'b1; end
      3'b100: c.xtal = 1'b1;
      default: c = '0;
    endcase
    c.ost_req = c.xtal;
    return c;
  endfunction

endpackage

// File: rtl/bor_glitch_filt.sv
module bor_glitch_filt #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic filt_o
);
  localparam int unsigned FW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

  logic [1:0]    sync_q;
  logic [FW-1:0] run_q;
  logic          filt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[0], raw_i};
  end

  // flip only after FILT_LEN consecutive samples opposite to the output
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      filt_q <= 1'b0;
    end else if (sync_q[1] == filt_q) begin
      run_q <= '0;
    end else if (run_q == FW'(FILT_LEN - 1)) begin
      run_q  <= '0;
      filt_q <= sync_q[1];
    end else begin
      run_q <= run_q + 1'b1;
    end
  end

  assign filt_o = filt_q;

  a_r6_flip_after_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (filt_q != $past(filt_q)) |-> ($past(sync_q[1]) == filt_q));

endmodule

// File: rtl/bor_cyc_timer.sv
module bor_cyc_timer #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] limit_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (cnt_q < limit_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q >= limit_i);

  a_r7_clr_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/bor_rst_seq.sv
module bor_rst_seq #(
  parameter int unsigned OST_CYC  = 12,
  parameter int unsigned FSCM_CYC = 25,
  parameter int unsigned REG_CYC  = 30,
  parameter int unsigned PWRT_W   = 6,
  parameter int unsigned FILT_LEN = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bor_trip_i,
  input  logic              por_i,
  input  logic [2:0]        osc_sel_i,
  input  logic [1:0]        posc_mode_i,
  input  logic [PWRT_W-1:0] pwrt_cyc_i,
  input  logic              pll_lock_i,
  input  logic              sleep_i,
  input  logic              idle_i,
  input  logic              clr_bor_flag_i,
  input  logic              clr_por_flag_i,
  output logic              core_rst_o,
  output logic              clk_en_o,
  output logic              exec_en_o,
  output logic              bor_flag_o,
  output logic              por_flag_o
);
  import bor_seq_pkg::*;

  localparam int unsigned MAXC  = max2(max2(OST_CYC, FSCM_CYC),
                                       max2(REG_CYC, (2 ** PWRT_W) - 1));
  localparam int unsigned CNT_W = $clog2(MAXC + 1);
  localparam int unsigned NTMR  = 3;  // 0: osc start-up, 1: power-up, 2: regulator

  logic                 bor_filt;
  logic                 trig;
  clk_cfg_t             cfg;
  logic [CNT_W-1:0]     lim [NTMR];
  logic [NTMR-1:0]      tdone;
  logic                 pll_ok, clk_qual, pwr_ok;
  logic                 clk_ok_q, rel_q, exec_q;
  logic                 bor_flag_q, por_flag_q;

  bor_glitch_filt #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (bor_trip_i),
    .filt_o (bor_filt)
  );

  assign trig = por_i | bor_filt;
  assign cfg  = decode_clk(osc_sel_i, posc_mode_i);

  always_comb begin
    lim[0] = cfg.ost_req ? CNT_W'(OST_CYC) : '0;
    lim[1] = (cfg.xtal && (pwrt_cyc_i == '0)) ? CNT_W'(FSCM_CYC) : CNT_W'(pwrt_cyc_i);
    lim[2] = CNT_W'(REG_CYC);
  end

  for (genvar g = 0; g < NTMR; g++) begin : g_tmr
    bor_cyc_timer #(.W(CNT_W)) u_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (trig),
      .limit_i (lim[g]),
      .done_o  (tdone[g])
    );
  end

  assign pll_ok   = ~cfg.pll_req | pll_lock_i;
  assign clk_qual = tdone[0] & pll_ok;
  assign pwr_ok   = clk_qual & tdone[1];

  // qualification, release and execution latch once reached, drop on trigger
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_ok_q <= 1'b0;
      rel_q    <= 1'b0;
      exec_q   <= 1'b0;
    end else if (trig) begin
      clk_ok_q <= 1'b0;
      rel_q    <= 1'b0;
      exec_q   <= 1'b0;
    end else begin
      clk_ok_q <= clk_ok_q | clk_qual;
      rel_q    <= rel_q | pwr_ok;
      exec_q   <= exec_q | (pwr_ok & tdone[2]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bor_flag_q <= 1'b0;
      por_flag_q <= 1'b0;
    end else begin
      if (bor_filt)            bor_flag_q <= 1'b1;
      else if (clr_bor_flag_i) bor_flag_q <= 1'b0;
      if (por_i)               por_flag_q <= 1'b1;
      else if (clr_por_flag_i) por_flag_q <= 1'b0;
    end
  end

  assign core_rst_o = ~rel_q;
  assign clk_en_o   = clk_ok_q & ~sleep_i;
  assign exec_en_o  = exec_q & ~sleep_i & ~idle_i;
  assign bor_flag_o = bor_flag_q;
  assign por_flag_o = por_flag_q;

  a_r7_trip_forces_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig |=> core_rst_o);
  a_r3_release_needs_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rel_q |-> clk_ok_q);
  a_r9_exec_needs_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_q |-> rel_q);
  a_r8_bor_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bor_flag_q && !clr_bor_flag_i) |=> bor_flag_q);
  a_r8_por_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> por_flag_q);
  a_r10_sleep_gates: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> (!clk_en_o && !exec_en_o));

endmodule

// File: tb/bor_rst_seq_bench.sv
module bor_rst_seq_bench;
  localparam int FILT = 3;
  localparam int OST  = 12;
  localparam int FSCM = 25;
  localparam int REG  = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bor = 1'b0, por = 1'b0, lock = 1'b0, slp = 1'b0, idl = 1'b0;
  logic clr_b = 1'b0, clr_p = 1'b0;
  logic [2:0] osel = 3'b000;
  logic [1:0] pmode = 2'b11;
  logic [5:0] pwrt = 6'd10;
  logic core_rst, clk_en, exec_en, bflag, pflag;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  bor_rst_seq u_bor_rst_seq (
    .clk_i(clk), .rst_ni(rst_n), .bor_trip_i(bor), .por_i(por),
    .osc_sel_i(osel), .posc_mode_i(pmode), .pwrt_cyc_i(pwrt),
    .pll_lock_i(lock), .sleep_i(slp), .idle_i(idl),
    .clr_bor_flag_i(clr_b), .clr_por_flag_i(clr_p),
    .core_rst_o(core_rst), .clk_en_o(clk_en), .exec_en_o(exec_en),
    .bor_flag_o(bflag), .por_flag_o(pflag)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic por_pulse();
    @(negedge clk) por = 1'b1;
    wait_n(3);
    por = 1'b0;
  endtask

  task automatic t_reset();
    #5;
    chk("R1", "core_rst in reset", core_rst, 1'b1);
    chk("R1", "clk_en in reset", clk_en, 1'b0);
    chk("R1", "exec_en in reset", exec_en, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    wait_n(0);
    chk("R1", "core_rst after reset", core_rst, 1'b1);
    chk("R1", "bor_flag after reset", bflag, 1'b0);
    chk("R1", "por_flag after reset", pflag, 1'b0);
    wait_n(40);
  endtask

  task automatic t_por_rc();
    osel = 3'b000; pmode = 2'b11; pwrt = 6'd10;
    por_pulse();
    wait_n(1);
    chk("R2", "clk_en one edge after por", clk_en, 1'b1);
    wait_n(9);
    chk("R2", "core_rst at N edges", core_rst, 1'b1);
    wait_n(1);
    chk("R2", "core_rst at N+1 edges", core_rst, 1'b0);
    chk("R2", "por_flag", pflag, 1'b1);
    wait_n(REG - 11);
    chk("R9", "exec_en at REG edges", exec_en, 1'b0);
    wait_n(1);
    chk("R9", "exec_en at REG+1 edges", exec_en, 1'b1);
  endtask

  task automatic t_xtal();
    osel = 3'b010; pmode = 2'b01; pwrt = 6'd10;
    por_pulse();
    wait_n(OST);
    chk("R3", "core_rst at OST edges", core_rst, 1'b1);
    chk("R3", "clk_en at OST edges", clk_en, 1'b0);
    wait_n(1);
    chk("R3", "core_rst at OST+1 edges", core_rst, 1'b0);
    chk("R3", "clk_en at OST+1 edges", clk_en, 1'b1);
    wait_n(40);
  endtask

  task automatic t_fscm();
    osel = 3'b010; pmode = 2'b10; pwrt = 6'd0;
    por_pulse();
    wait_n(FSCM);
    chk("R5", "core_rst at FSCM edges", core_rst, 1'b1);
    wait_n(1);
    chk("R5", "core_rst at FSCM+1 edges", core_rst, 1'b0);
    wait_n(40);
    pmode = 2'b00;
    por_pulse();
    chk("R5", "ext clock still reset at por end", core_rst, 1'b1);
    wait_n(1);
    chk("R5", "ext clock no delay release", core_rst, 1'b0);
    wait_n(40);
  endtask

  task automatic t_pll();
    osel = 3'b001; pmode = 2'b11; pwrt = 6'd10; lock = 1'b0;
    por_pulse();
    wait_n(20);
    chk("R4", "core_rst without lock", core_rst, 1'b1);
    chk("R4", "clk_en without lock", clk_en, 1'b0);
    lock = 1'b1;
    wait_n(1);
    chk("R4", "core_rst after lock", core_rst, 1'b0);
    chk("R4", "clk_en after lock", clk_en, 1'b1);
    wait_n(40);
    osel = 3'b000;
  endtask

  task automatic t_trip();
    osel = 3'b000; pmode = 2'b11; pwrt = 6'd10;
    bor = 1'b1;
    wait_n(FILT - 1);
    bor = 1'b0;
    wait_n(8);
    chk("R6", "short pulse core_rst", core_rst, 1'b0);
    chk("R6", "short pulse bor_flag", bflag, 1'b0);
    bor = 1'b1;
    wait_n(FILT + 2);
    chk("R6", "trip before filter", core_rst, 1'b0);
    wait_n(1);
    chk("R6", "trip asserts core_rst", core_rst, 1'b1);
    chk("R8", "bor_flag set by trip", bflag, 1'b1);
    wait_n(5);
    bor = 1'b0;
    wait_n(FILT + 2 + 10);
    chk("R6", "still reset after trip end", core_rst, 1'b1);
    wait_n(1);
    chk("R6", "release after trip end", core_rst, 1'b0);
    wait_n(40);
  endtask

  task automatic t_restart();
    por_pulse();
    wait_n(5);
    bor = 1'b1;
    wait_n(10);
    chk("R7", "trip mid sequence", core_rst, 1'b1);
    bor = 1'b0;
    wait_n(FILT + 2 + 10);
    chk("R7", "counters restarted", core_rst, 1'b1);
    wait_n(1);
    chk("R7", "release from new trip end", core_rst, 1'b0);
    wait_n(40);
  endtask

  task automatic t_flags();
    clr_b = 1'b1;
    wait_n(1);
    clr_b = 1'b0;
    chk("R8", "bor_flag cleared", bflag, 1'b0);
    chk("R8", "por_flag kept", pflag, 1'b1);
    clr_p = 1'b1;
    wait_n(1);
    clr_p = 1'b0;
    chk("R8", "por_flag cleared", pflag, 1'b0);
    por = 1'b1; clr_p = 1'b1;
    wait_n(1);
    por = 1'b0; clr_p = 1'b0;
    chk("R8", "set wins over clear", pflag, 1'b1);
    chk("R8", "bor_flag stays clear", bflag, 1'b0);
    wait_n(40);
  endtask

  task automatic t_lowpower();
    slp = 1'b1;
    #1;
    chk("R10", "sleep clk_en", clk_en, 1'b0);
    chk("R10", "sleep exec_en", exec_en, 1'b0);
    chk("R10", "sleep core_rst", core_rst, 1'b0);
    wait_n(0);
    bor = 1'b1;
    wait_n(FILT + 3);
    chk("R10", "trip in sleep core_rst", core_rst, 1'b1);
    chk("R10", "trip in sleep bor_flag", bflag, 1'b1);
    bor = 1'b0;
    wait_n(FILT + 3 + 10);
    chk("R10", "release in sleep", core_rst, 1'b0);
    chk("R10", "clk_en gated in sleep", clk_en, 1'b0);
    slp = 1'b0; idl = 1'b1;
    wait_n(REG);
    chk("R10", "idle clk_en", clk_en, 1'b1);
    chk("R10", "idle exec_en", exec_en, 1'b0);
    idl = 1'b0;
    #1;
    chk("R10", "exec_en after idle", exec_en, 1'b1);
  endtask

  initial begin
    t_reset();
    t_por_rc();
    t_xtal();
    t_fscm();
    t_pll();
    t_trip();
    t_restart();
    t_flags();
    t_lowpower();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule